// File: doc/BRIEF.md
# Virtual Channel Video Format Bridge

This block sits after a camera-link packet receiver. Its input is a byte-wide AXI4-Stream that carries the payload of long packets. On each beat, TDEST holds the virtual channel in bits 1:0 and the six-bit data type in bits 7:2. TUSER bit 0 flags the first beat of a frame and TUSER bit 1 flags a packet that ended because of an error. The bridge decides once per packet, on its first beat, whether the packet is kept. A kept packet must arrive on the configured virtual channel and carry an accepted data type.

The payload of a kept packet is turned into pixels and packed into a video stream with a fixed number of pixels per beat. Output TUSER marks the start of a frame and TLAST marks the end of a line. The port width is sized for the widest pixel the bridge can emit. Narrower pixels are packed from bit 0 upwards, with nothing between them.

The pixel count per beat and the main data type, 8-bit or 10-bit raw, are elaboration parameters. The virtual channel selection is a quasi-static input. Full back-pressure applies in both directions.

Top module: `vc_fmt_bridge`

## Requirements
- R1: A packet is forwarded only when TDEST[1:0] on its first beat equals `cfg_vc`. A packet that is not forwarded is consumed with `s_tready` held high and produces no output beat.
- R2: Data type 0x2A (8-bit raw) and the byte-based types 0x30 to 0x37 are always kept. Data type 0x2B (10-bit raw) is kept only when it is the configured main type. Every other data type is dropped.
- R3: The width of `m_tdata` is the larger of 8 and the main pixel width, times `PPB`, rounded up to a multiple of 8. For the defaults (10-bit main type, 2 pixels per beat) this gives 24.
- R4: For a byte-based type, input byte n of a line becomes pixel n. Pixel i of a beat sits at bits [8i+7:8i], and all bits above the filled pixels are zero.
- R5: For 10-bit raw, each 5-byte group yields 4 pixels. Pixel k takes byte k as its bits 9:2 and bits [2k+1:2k] of byte 4 as its bits 1:0. Pixel i of a beat sits at bits [10i+9:10i], and the bits above are zero.
- R6: The beat holding the last pixel of a line has `m_tlast` set. If the line length is not a multiple of `PPB`, that beat is still a full-width word, with zeros in the empty pixel slots.
- R7: `m_tuser` is 1 on the beat holding the first pixel of a packet whose first input beat had TUSER[0] set. It is 0 on every other beat.
- R8: An input beat with TUSER[1] set ends the packet in the same way as TLAST. If a 10-bit group is cut short by such a beat or by TLAST, each received byte of the group becomes a pixel with bits 1:0 zero, and the line closes with `m_tlast`.
- R9: A change of `cfg_vc` after the first beat of a packet has no effect on that packet.
- R10: While `m_tvalid` is high and `m_tready` is low, `m_tdata`, `m_tuser` and `m_tlast` hold steady. Under random stalls on either side, no pixel is lost or repeated.
- R11: After reset, `m_tvalid` is low and `s_tready` is high while the input is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_vc | input | 2 | Selected virtual channel, sampled at packet start |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tdata | input | 8 | Payload byte |
| s_tdest | input | 8 | Bits 7:2 data type, bits 1:0 virtual channel |
| s_tuser | input | 2 | Bit 0 frame start, bit 1 packet error end |
| s_tlast | input | 1 | Last byte of the packet |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Output beat accepted |
| m_tdata | output | OUT_W | Packed pixels, pixel 0 in the lowest bits |
| m_tuser | output | 1 | Start of frame |
| m_tlast | output | 1 | End of line |

## Verification
The bench targets lines whose pixel count is not a multiple of the beat size. A faulty packer would leave stale pixels in the empty slots or fail to close the line. It checks 10-bit groups cut short by the error flag. A design that waited for the fifth byte would hang, or would merge the end of the line into the next packet. It changes the virtual channel in the middle of a packet and sends packets with unknown types or on other channels. Re-sampling the channel per beat would cut the line short, and treating filtered packets as data would leak output beats or stall the source. Random stalls on both sides expose a pixel buffer that overwrites or repeats pixels when the output is held.

// File: rtl/vfb_pkg.sv
package vfb_pkg;

  localparam logic [5:0] DT_RAW8  = 6'h2A;
  localparam logic [5:0] DT_RAW10 = 6'h2B;

  // byte-based types: 8-bit raw and the user range 0x30..0x37
  function automatic logic is_byte_type(logic [5:0] dt);
    return (dt == DT_RAW8) || (dt[5:3] == 3'b110);
  endfunction

  function automatic int unsigned pix_width(logic [5:0] main_dt);
    return (main_dt == DT_RAW10) ? 10 : 8;
  endfunction

  function automatic int unsigned out_width(int unsigned pw, int unsigned ppb);
    int unsigned bits;
    bits = ((pw > 8) ? pw : 8) * ppb;
    return ((bits + 7) / 8) * 8;
  endfunction

  // join high byte with the 2-bit share taken from the packed low byte
  function automatic logic [9:0] raw10_join(logic [7:0] hi, logic [7:0] lo_byte,
                                            int unsigned idx);
    return {hi, lo_byte[2*idx +: 2]};
  endfunction

endpackage

// File: rtl/vfb_filter.sv
module vfb_filter #(
  parameter logic [5:0] MAIN_DT = vfb_pkg::DT_RAW10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat_fire,
  input  logic       beat_end,
  input  logic [5:0] dt,
  input  logic [1:0] vc,
  input  logic [1:0] cfg_vc,
  output logic       keep,
  output logic       raw10,
  output logic       first
);
  import vfb_pkg::*;

  logic in_pkt, pkt_keep, pkt_raw10;
  logic type_ok, new_keep, new_raw10;

  assign type_ok   = is_byte_type(dt) || ((MAIN_DT == DT_RAW10) && (dt == DT_RAW10));
  assign new_keep  = type_ok && (vc == cfg_vc);
  assign new_raw10 = (dt == DT_RAW10);

  assign first = !in_pkt;
  assign keep  = in_pkt ? pkt_keep  : new_keep;
  assign raw10 = in_pkt ? pkt_raw10 : new_raw10;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt    <= 1'b0;
      pkt_keep  <= 1'b0;
      pkt_raw10 <= 1'b0;
    end else if (beat_fire) begin
      if (beat_end) begin
        in_pkt <= 1'b0;
      end else if (!in_pkt) begin
        in_pkt    <= 1'b1;
        pkt_keep  <= new_keep;
        pkt_raw10 <= new_raw10;
      end
    end
  end

  AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && !(beat_fire && beat_end)) |=> (in_pkt && $stable(keep))); // R9

endmodule

// File: rtl/vfb_unpack.sv
module vfb_unpack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_raw10,
  input  logic       in_last,
  input  logic       in_sof,
  output logic       in_ready,
  output logic       px_valid,
  output logic [9:0] px_data,
  output logic       px_raw10,
  output logic       px_sof,
  output logic       px_eol,
  input  logic       px_ready
);
  import vfb_pkg::*;

  logic [9:0] pix [4];
  logic [7:0] msb [4];
  logic [2:0] cnt, rd, grp, left;
  logic       ld_sof, ld_eol, ld_raw10, grp_sof;

  logic       px_fire, loads, free, in_fire;
  logic [9:0] nxt_pix [4];
  logic [2:0] nxt_cnt;
  logic       nxt_sof;

  assign left     = cnt - rd;
  assign px_valid = (left != 3'd0);
  assign px_data  = pix[rd[1:0]];
  assign px_raw10 = ld_raw10;
  assign px_sof   = ld_sof && (rd == 3'd0);
  assign px_eol   = ld_eol && ((rd + 3'd1) == cnt);
  assign px_fire  = px_valid && px_ready;

  // a byte that completes pixels needs the pixel buffer to be free
  assign loads    = !in_raw10 || in_last || (grp == 3'd4);
  assign free     = (left == 3'd0) || ((left == 3'd1) && px_fire);
  assign in_ready = loads ? free : 1'b1;
  assign in_fire  = in_valid && in_ready;

  always_comb begin
    for (int k = 0; k < 4; k++) nxt_pix[k] = '0;
    nxt_cnt = 3'd1;
    nxt_sof = in_sof;
    if (!in_raw10) begin
      nxt_pix[0] = {2'b00, in_data};
    end else if (grp == 3'd4) begin
      for (int k = 0; k < 4; k++) nxt_pix[k] = raw10_join(msb[k], in_data, k);
      nxt_cnt = 3'd4;
      nxt_sof = grp_sof;
    end else begin
      // truncated group: received high bytes become pixels, low bits zero
      for (int k = 0; k < 4; k++) begin
        if (3'(k) < grp)       nxt_pix[k] = {msb[k], 2'b00};
        else if (3'(k) == grp) nxt_pix[k] = {in_data, 2'b00};
      end
      nxt_cnt = grp + 3'd1;
      nxt_sof = (grp == 3'd0) ? in_sof : grp_sof;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        pix[k] <= '0;
        msb[k] <= '0;
      end
      cnt      <= '0;
      rd       <= '0;
      grp      <= '0;
      ld_sof   <= 1'b0;
      ld_eol   <= 1'b0;
      ld_raw10 <= 1'b0;
      grp_sof  <= 1'b0;
    end else begin
      if (px_fire) rd <= rd + 3'd1;
      if (in_fire) begin
        if (loads) begin
          for (int k = 0; k < 4; k++) pix[k] <= nxt_pix[k];
          cnt      <= nxt_cnt;
          rd       <= '0;
          ld_sof   <= nxt_sof;
          ld_eol   <= in_last;
          ld_raw10 <= in_raw10;
          if (in_raw10) grp <= '0;
        end else begin
          msb[grp[1:0]] <= in_data;
          grp           <= grp + 3'd1;
          if (grp == 3'd0) grp_sof <= in_sof;
        end
      end
    end
  end

  AST_GROUP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    grp <= 3'd4); // R5

  AST_PIXEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_data) && $stable(px_eol))); // R10

endmodule

// File: rtl/vfb_packer.sv
module vfb_packer #(
  parameter int PPB   = 2,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             px_valid,
  input  logic [9:0]       px_data,
  input  logic             px_raw10,
  input  logic             px_sof,
  input  logic             px_eol,
  output logic             px_ready,
  output logic             m_tvalid,
  output logic [OUT_W-1:0] m_tdata,
  output logic             m_tuser,
  output logic             m_tlast,
  input  logic             m_tready
);
  localparam int FW = $clog2(PPB) + 1;

  logic [9:0]    slot [PPB];
  logic [FW-1:0] fill;
  logic          o_valid, o_sof, o_eol, beat_raw10;
  logic          take, complete;

  assign px_ready = !o_valid || m_tready;
  assign take     = px_valid && px_ready;
  assign complete = (fill == FW'(PPB - 1)) || px_eol;

  assign m_tvalid = o_valid;
  assign m_tuser  = o_sof;
  assign m_tlast  = o_eol;

  // pack pixels contiguously from bit 0 at the stride of the beat's type
  always_comb begin
    m_tdata = '0;
    for (int i = 0; i < PPB; i++) begin
      if (beat_raw10) m_tdata = m_tdata | (OUT_W'(slot[i]) << (i * 10));
      else            m_tdata = m_tdata | (OUT_W'(slot[i][7:0]) << (i * 8));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PPB; i++) slot[i] <= '0;
      fill       <= '0;
      o_valid    <= 1'b0;
      o_sof      <= 1'b0;
      o_eol      <= 1'b0;
      beat_raw10 <= 1'b0;
    end else begin
      if (o_valid && m_tready) o_valid <= 1'b0;
      if (take) begin
        for (int i = 0; i < PPB; i++) begin
          if (fill == '0)           slot[i] <= (i == 0) ? px_data : '0;
          else if (FW'(i) == fill)  slot[i] <= px_data;
        end
        if (fill == '0) begin
          o_sof      <= px_sof;
          beat_raw10 <= px_raw10;
        end
        if (complete) begin
          fill    <= '0;
          o_valid <= 1'b1;
          o_eol   <= px_eol;
        end else begin
          fill <= fill + 1'b1;
        end
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast))); // R10

  AST_EOL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && px_eol) |=> (m_tvalid && m_tlast)); // R6

  AST_FULL_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(m_tvalid) && !m_tlast) |-> ($past(fill) == FW'(PPB - 1))); // R6

endmodule

// File: rtl/vc_fmt_bridge.sv
module vc_fmt_bridge #(
  parameter int         PPB     = 2,
  parameter logic [5:0] MAIN_DT = vfb_pkg::DT_RAW10,
  localparam int        OUT_W   = vfb_pkg::out_width(vfb_pkg::pix_width(MAIN_DT), PPB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_vc,
  input  logic             s_tvalid,
  output logic             s_tready,
  input  logic [7:0]       s_tdata,
  input  logic [7:0]       s_tdest,
  input  logic [1:0]       s_tuser,
  input  logic             s_tlast,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic [OUT_W-1:0] m_tdata,
  output logic             m_tuser,
  output logic             m_tlast
);
  logic       keep, raw10, first, pkt_end, beat_fire;
  logic       up_ready, up_valid;
  logic       px_valid, px_ready, px_raw10, px_sof, px_eol;
  logic [9:0] px_data;

  // an error-flagged beat closes the packet just like TLAST
  assign pkt_end   = s_tlast || s_tuser[1];
  assign up_valid  = s_tvalid && keep;
  assign s_tready  = keep ? up_ready : 1'b1;
  assign beat_fire = s_tvalid && s_tready;

  vfb_filter #(.MAIN_DT(MAIN_DT)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_fire(beat_fire),
    .beat_end (pkt_end),
    .dt       (s_tdest[7:2]),
    .vc       (s_tdest[1:0]),
    .cfg_vc   (cfg_vc),
    .keep     (keep),
    .raw10    (raw10),
    .first    (first)
  );

  vfb_unpack u_unpack (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(up_valid),
    .in_data (s_tdata),
    .in_raw10(raw10),
    .in_last (pkt_end),
    .in_sof  (s_tuser[0] && first),
    .in_ready(up_ready),
    .px_valid(px_valid),
    .px_data (px_data),
    .px_raw10(px_raw10),
    .px_sof  (px_sof),
    .px_eol  (px_eol),
    .px_ready(px_ready)
  );

  vfb_packer #(.PPB(PPB), .OUT_W(OUT_W)) u_packer (
    .clk     (clk),
    .rst_n   (rst_n),
    .px_valid(px_valid),
    .px_data (px_data),
    .px_raw10(px_raw10),
    .px_sof  (px_sof),
    .px_eol  (px_eol),
    .px_ready(px_ready),
    .m_tvalid(m_tvalid),
    .m_tdata (m_tdata),
    .m_tuser (m_tuser),
    .m_tlast (m_tlast),
    .m_tready(m_tready)
  );

  AST_DROPPED_NOT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && !keep && !px_valid) |=> !px_valid); // R1

endmodule

// File: tb/vc_fmt_bridge_tb.sv
`timescale 1ns/1ps
module vc_fmt_bridge_tb;

  localparam int EXP_W = ((((10 > 8) ? 10 : 8) * 2 + 7) / 8) * 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       cfg_vc = 2'd1;
  logic             s_tvalid = 1'b0;
  logic             s_tready;
  logic [7:0]       s_tdata = '0;
  logic [7:0]       s_tdest = '0;
  logic [1:0]       s_tuser = '0;
  logic             s_tlast = 1'b0;
  logic             m_tvalid;
  logic             m_tready = 1'b1;
  logic [EXP_W-1:0] m_tdata;
  logic             m_tuser;
  logic             m_tlast;

  vc_fmt_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_vc(cfg_vc),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .s_tdest(s_tdest), .s_tuser(s_tuser), .s_tlast(s_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tuser(m_tuser), .m_tlast(m_tlast)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit stall_en = 1'b0;
  bit gaps = 1'b0;

  logic [7:0]       pkt_b [64];
  logic [EXP_W-1:0] exp_data [128];
  logic             exp_user [128];
  logic             exp_last [128];
  int               exp_n = 0;
  logic [EXP_W-1:0] got_data [128];
  logic             got_user [128];
  logic             got_last [128];
  int               got_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // output ready pattern
  always begin
    @(negedge clk);
    m_tready = stall_en ? ($urandom_range(2) != 0) : 1'b1;
  end

  // monitor: sample between edges, record accepted beats, check holding
  bit               hold_prev = 1'b0;
  logic [EXP_W-1:0] hold_data;
  logic             hold_last, hold_user;
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (hold_prev)
        chk(m_tvalid && (m_tdata == hold_data) && (m_tlast == hold_last) && (m_tuser == hold_user),
            "R10", "held beat changed", longint'(m_tdata), longint'(hold_data));
      if (m_tvalid && m_tready && got_n < 128) begin
        got_data[got_n] = m_tdata;
        got_user[got_n] = m_tuser;
        got_last[got_n] = m_tlast;
        got_n++;
      end
      hold_prev = m_tvalid && !m_tready;
      hold_data = m_tdata;
      hold_last = m_tlast;
      hold_user = m_tuser;
    end
  end

  task automatic fill_bytes(input int n, input int seed);
    for (int i = 0; i < n; i++) pkt_b[i] = 8'((seed + i * 37 + (i >> 2) * 11) & 8'hFF);
  endtask

  // expected beats for one kept line, 2 pixels per beat
  task automatic expect_line(input bit r10, input int n, input bit sof);
    logic [9:0] px [64];
    int np = 0;
    int g = 0;
    logic [EXP_W-1:0] w;
    if (r10) begin
      while (g + 5 <= n) begin
        for (int k = 0; k < 4; k++) px[np++] = {pkt_b[g+k], pkt_b[g+4][2*k +: 2]};
        g += 5;
      end
      for (int k = g; k < n; k++) px[np++] = {pkt_b[k], 2'b00};
    end else begin
      for (int k = 0; k < n; k++) px[np++] = {2'b00, pkt_b[k]};
    end
    for (int b = 0; b < np; b += 2) begin
      w = '0;
      for (int j = 0; j < 2; j++)
        if (b + j < np)
          w = w | (EXP_W'(r10 ? px[b+j] : {2'b00, px[b+j][7:0]}) << (j * (r10 ? 10 : 8)));
      exp_data[exp_n] = w;
      exp_user[exp_n] = sof && (b == 0);
      exp_last[exp_n] = (b + 2 >= np);
      exp_n++;
    end
  endtask

  task automatic send_pkt(input logic [5:0] dt, input logic [1:0] vc, input int n,
                          input bit sof, input bit err_end, input int swap_at,
                          output int stalls);
    bit rdy;
    stalls = 0;
    for (int i = 0; i < n; i++) begin
      if (gaps && $urandom_range(3) == 0) begin
        @(negedge clk);
        s_tvalid = 1'b0;
      end
      @(negedge clk);
      if (i == swap_at) cfg_vc = cfg_vc ^ 2'b10;
      s_tvalid = 1'b1;
      s_tdata  = pkt_b[i];
      s_tdest  = {dt, vc};
      s_tuser  = {err_end && (i == n - 1), sof && (i == 0)};
      s_tlast  = (i == n - 1) && !err_end;
      forever begin
        #1;
        rdy = s_tready;
        @(posedge clk);
        if (rdy) break;
        stalls++;
        @(negedge clk);
      end
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
    s_tuser  = '0;
  endtask

  task automatic check_beats(input string req);
    for (int t = 0; t < 600 && got_n < exp_n; t++) @(posedge clk);
    repeat (8) @(posedge clk);
    chk(got_n == exp_n, req, "beat count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_data[i] == exp_data[i], req, $sformatf("data beat %0d", i),
          longint'(got_data[i]), longint'(exp_data[i]));
      chk(got_user[i] == exp_user[i], req, $sformatf("tuser beat %0d", i), got_user[i], exp_user[i]);
      chk(got_last[i] == exp_last[i], req, $sformatf("tlast beat %0d", i), got_last[i], exp_last[i]);
    end
    exp_n = 0;
    got_n = 0;
  endtask

  task automatic t_reset();
    #1;
    chk(m_tvalid == 1'b0, "R11", "tvalid after reset", m_tvalid, 0);
    chk(s_tready == 1'b1, "R11", "tready after reset", s_tready, 1);
    chk($bits(u_dut.m_tdata) == EXP_W, "R3", "output width", $bits(u_dut.m_tdata), EXP_W);
  endtask

  task automatic t_raw8_lines();
    int st;
    fill_bytes(6, 8'h11);
    expect_line(1'b0, 6, 1'b1);
    send_pkt(6'h2A, 2'd1, 6, 1'b1, 1'b0, -1, st);
    check_beats("R4 R7");
    fill_bytes(5, 8'h5C);
    expect_line(1'b0, 5, 1'b0);
    send_pkt(6'h2A, 2'd1, 5, 1'b0, 1'b0, -1, st);
    check_beats("R6");
  endtask

  task automatic t_raw10_lines();
    int st;
    fill_bytes(10, 8'hA3);
    expect_line(1'b1, 10, 1'b1);
    send_pkt(6'h2B, 2'd1, 10, 1'b1, 1'b0, -1, st);
    check_beats("R5");
    fill_bytes(8, 8'h37);
    expect_line(1'b1, 8, 1'b0);
    send_pkt(6'h2B, 2'd1, 8, 1'b0, 1'b0, -1, st);
    check_beats("R8 tlast mid-group");
  endtask

  task automatic t_type_filter();
    int st;
    int tot = 0;
    fill_bytes(6, 8'h42);
    send_pkt(6'h2C, 2'd1, 6, 1'b1, 1'b0, -1, st); tot += st;
    send_pkt(6'h38, 2'd1, 6, 1'b0, 1'b0, -1, st); tot += st;
    send_pkt(6'h24, 2'd1, 6, 1'b0, 1'b0, -1, st); tot += st;
    chk(tot == 0, "R2", "stall on dropped types", tot, 0);
    check_beats("R2 dropped types");
    fill_bytes(7, 8'h90);
    expect_line(1'b0, 7, 1'b0);
    send_pkt(6'h35, 2'd1, 7, 1'b0, 1'b0, -1, st);
    check_beats("R2 user byte type");
  endtask

  task automatic t_vc_filter();
    int st;
    fill_bytes(10, 8'h21);
    send_pkt(6'h2B, 2'd2, 10, 1'b1, 1'b0, -1, st);
    chk(st == 0, "R1", "stall on other channel", st, 0);
    check_beats("R1 other channel");
    fill_bytes(9, 8'hC4);
    expect_line(1'b0, 9, 1'b1);
    send_pkt(6'h2A, 2'd1, 9, 1'b1, 1'b0, 1, st);
    check_beats("R9 channel change mid-packet");
    cfg_vc = 2'd1;
  endtask

  task automatic t_error_end();
    int st;
    fill_bytes(7, 8'h6E);
    expect_line(1'b1, 7, 1'b1);
    send_pkt(6'h2B, 2'd1, 7, 1'b1, 1'b1, -1, st);
    check_beats("R8 error flag truncation");
    fill_bytes(3, 8'h19);
    expect_line(1'b0, 3, 1'b0);
    send_pkt(6'h2A, 2'd1, 3, 1'b0, 1'b1, -1, st);
    check_beats("R8 error flag byte type");
  endtask

  task automatic t_stall();
    int st;
    stall_en = 1'b1;
    gaps = 1'b1;
    fill_bytes(40, 8'h07);
    expect_line(1'b1, 40, 1'b1);
    send_pkt(6'h2B, 2'd1, 40, 1'b1, 1'b0, -1, st);
    fill_bytes(30, 8'hE1);
    expect_line(1'b0, 30, 1'b0);
    send_pkt(6'h31, 2'd1, 30, 1'b0, 1'b0, -1, st);
    fill_bytes(13, 8'h3D);
    expect_line(1'b1, 13, 1'b0);
    send_pkt(6'h2B, 2'd1, 13, 1'b0, 1'b0, -1, st);
    check_beats("R10 random stalls");
    stall_en = 1'b0;
    gaps = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw8_lines();
    t_raw10_lines();
    t_type_filter();
    t_vc_filter();
    t_error_end();
    t_stall();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule